// File: doc/BRIEF.md
# Nonvolatile SRAM Key-Sequence Transfer Controller

This block models a small static RAM paired with a shadow nonvolatile array, plus the controller that moves data between them. Normal accesses use an active-low chip enable, a write enable and an output enable, with a 13-bit address and an 8-bit data path. The controller watches the read traffic for a fixed key of six addresses. The first five addresses are common to both commands. The sixth address decides the command: one value restores the SRAM from the shadow array, and the other saves the SRAM into the shadow array.

When a valid key completes, the controller raises `busy` for a parameterized number of clock cycles and the array ignores all accesses for that time. A restore first clears every SRAM word and then loads the shadow contents. A save copies the SRAM into the shadow array. A `pwr_good` input reports whether the supply is above the switch threshold. While it is low, writes to the SRAM are dropped and save commands are not carried out.

Top module: `nvsram_seq`

## Requirements
- R1: After reset, `busy` is 0, `rdata` reads 0, and every word of both arrays holds 0.
- R2: An access is the first clock cycle in which `ce_n` is low after a cycle in which it was high. Holding `we_n` low makes the access a write and holding it high makes it a read. The word index is `addr[IDX_W-1:0]`. A read loads the addressed word into the output register, and that value appears on `rdata` from the next cycle on, provided `oe_n` is low. While `oe_n` is high, `rdata` is 0.
- R3: Six read accesses in a row at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and 0x0F0E start a restore. `busy` goes high in the cycle after the sixth access and stays high for exactly `T_RECALL` cycles.
- R4: The same five-address prefix followed by a read at `STORE_LAST` (0x0FF0 by default) starts a save. `busy` is then high for exactly `T_STORE` cycles, and at the end the shadow array holds a copy of the SRAM.
- R5: A write access at any point in a partial key discards the progress made so far.
- R6: A read whose address does not match the next expected key address returns the matcher to idle. If that address equals 0x0000, it counts as the first step of a new key.
- R7: The level of `oe_n` has no effect on whether a read counts toward the key.
- R8: While `busy` is high, reads and writes are ignored: they neither change the arrays nor advance the key.
- R9: A restore clears the SRAM before it loads the shadow contents. It never modifies the shadow array, and it can be repeated any number of times with the same result.
- R10: While `pwr_good` is low, write accesses leave the SRAM unchanged, and a completed save key does not start a transfer.
- R11: Keeping `ce_n` low over several cycles makes a single access, so a held address never counts twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; its falling transition marks an access |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; gates `rdata` |
| addr | input | 13 | Access address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pwr_good | input | 1 | High while the supply is above the switch threshold |
| busy | output | 1 | High while a transfer runs and accesses are ignored |

## Verification
Read data is registered on the access edge, so the bench samples `rdata` on the falling clock edge right after that edge. A sixth key read raises `busy` on that same falling edge. The bench then counts falling edges until `busy` drops, and the count must equal exactly `T_RECALL` or `T_STORE`. Any write that the bench issues during a transfer is included in that count. Negative cases, such as a broken key, a save at low power, or an ignored write, are checked on the falling edge after the last access or by reading the word back through the normal read path.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

  typedef enum logic [1:0] {
    XF_IDLE   = 2'd0,
    XF_SAVE   = 2'd1,
    XF_RESTORE = 2'd2
  } xfer_mode_t;

  localparam int unsigned KEY_PREFIX_LEN = 5;
  localparam logic [12:0] KEY_FIRST      = 13'h0000;

  // Shared five-step key prefix; the sixth address selects the command.
  function automatic logic [12:0] key_prefix(input logic [2:0] step);
    logic [12:0] a;
    case (step)
      3'd0:    a = 13'h0000;
      3'd1:    a = 13'h1555;
      3'd2:    a = 13'h0AAA;
      3'd3:    a = 13'h1FFF;
      default: a = 13'h10F0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/nvsram_keymatch.sv
module nvsram_keymatch
  import nvsram_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter logic [12:0] RESTORE_LAST = 13'h0F0E,
  parameter logic [12:0] STORE_LAST  = 13'h0FF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_acc,
  input  logic              wr_acc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pwr_good,
  output logic              go_restore,
  output logic              go_save
);

  localparam logic [2:0] LAST_STEP = 3'(KEY_PREFIX_LEN);

  logic [2:0] step_q, step_d;
  logic       step_en;
  logic       hit_first;

  assign hit_first = (addr[12:0] == KEY_FIRST);
  assign step_en   = rd_acc | wr_acc;

  always_comb begin
    step_d     = step_q;
    go_restore = 1'b0;
    go_save    = 1'b0;
    if (wr_acc) begin
      step_d = 3'd0;
    end else if (rd_acc) begin
      if (step_q == LAST_STEP) begin
        if (addr[12:0] == RESTORE_LAST) begin
          go_restore = 1'b1;
          step_d     = 3'd0;
        end else if (addr[12:0] == STORE_LAST) begin
          go_save = pwr_good;
          step_d  = 3'd0;
        end else begin
          step_d = hit_first ? 3'd1 : 3'd0;
        end
      end else if (addr[12:0] == key_prefix(step_q)) begin
        step_d = step_q + 3'd1;
      end else begin
        step_d = hit_first ? 3'd1 : 3'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 3'd0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP); // R6
  AST_WRITE_BREAKS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> (step_q == 3'd0)); // R5
  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_restore && go_save)); // R3

endmodule

// File: rtl/nvsram_xfer.sv
module nvsram_xfer
  import nvsram_pkg::*;
#(
  parameter int unsigned T_STORE  = 20,
  parameter int unsigned T_RECALL = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_restore,
  input  logic       go_save,
  output logic       busy,
  output xfer_mode_t mode,
  output logic       clr_all,
  output logic       ld_from_nv,
  output logic       sv_to_nv
);

  localparam int unsigned T_MAX = (T_STORE > T_RECALL) ? T_STORE : T_RECALL;
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] RST_FIRST = CNT_W'(T_RECALL - 1);
  localparam logic [CNT_W-1:0] SAV_FIRST = CNT_W'(T_STORE - 1);

  initial begin
    assert (T_RECALL >= 2 && T_STORE >= 1);
  end

  xfer_mode_t       mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (mode_q == XF_IDLE) begin
      if (go_restore) begin
        mode_d = XF_RESTORE;
        cnt_d  = RST_FIRST;
      end else if (go_save) begin
        mode_d = XF_SAVE;
        cnt_d  = SAV_FIRST;
      end
    end else if (cnt_q == '0) begin
      mode_d = XF_IDLE;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= XF_IDLE;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy       = (mode_q != XF_IDLE);
  assign mode       = mode_q;
  assign clr_all    = (mode_q == XF_RESTORE) && (cnt_q == RST_FIRST);
  assign ld_from_nv = (mode_q == XF_RESTORE) && (cnt_q == '0);
  assign sv_to_nv   = (mode_q == XF_SAVE)    && (cnt_q == '0);

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (go_restore || go_save)) |=> busy); // R3
  AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && mode_q == XF_RESTORE) |-> clr_all); // R9
  AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_all, ld_from_nv, sv_to_nv})); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == XF_RESTORE) |-> (cnt_q <= RST_FIRST)); // R3

endmodule

// File: rtl/nvsram_store.sv
module nvsram_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_active,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_all,
  input  logic              ld_from_nv,
  input  logic              sv_to_nv,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] sram_q [DEPTH];
  logic [DATA_W-1:0] nv_q   [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // Volatile array: restore clear, restore load, then host writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sram_q[i] <= '0;
    end else if (clr_all) begin
      for (int i = 0; i < DEPTH; i++) sram_q[i] <= '0;
    end else if (ld_from_nv) begin
      for (int i = 0; i < DEPTH; i++) sram_q[i] <= nv_q[i];
    end else if (wr_en) begin
      sram_q[idx] <= wdata;
    end
  end

  // Shadow array: written only by a save.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) nv_q[i] <= '0;
    end else if (sv_to_nv) begin
      for (int i = 0; i < DEPTH; i++) nv_q[i] <= sram_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= sram_q[idx];
    end
  end

  assign rdata = rd_q;

  AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |-> !wr_en && !rd_en); // R8
  AST_NV_HELD_ON_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_from_nv |=> (nv_q[0] == $past(nv_q[0]))); // R9

endmodule

// File: rtl/nvsram_seq.sv
module nvsram_seq
  import nvsram_pkg::*;
#(
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned T_STORE      = 20,
  parameter int unsigned T_RECALL     = 8,
  parameter logic [12:0] RESTORE_LAST = 13'h0F0E,
  parameter logic [12:0] STORE_LAST   = 13'h0FF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pwr_good,
  output logic              busy
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic              ce_prev_q;
  logic              acc, live, rd_acc, wr_acc, wr_en;
  logic              go_restore, go_save;
  logic              clr_all, ld_from_nv, sv_to_nv;
  logic [DATA_W-1:0] rd_word;
  xfer_mode_t        mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev_q <= 1'b1;
    end else begin
      ce_prev_q <= ce_n;
    end
  end

  assign acc    = !ce_n && ce_prev_q;
  assign live   = acc && !busy;
  assign rd_acc = live && we_n;
  assign wr_acc = live && !we_n;
  assign wr_en  = wr_acc && pwr_good;

  nvsram_keymatch #(
    .ADDR_W      (ADDR_W),
    .RESTORE_LAST(RESTORE_LAST),
    .STORE_LAST  (STORE_LAST)
  ) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_acc    (rd_acc),
    .wr_acc    (wr_acc),
    .addr      (addr),
    .pwr_good  (pwr_good),
    .go_restore(go_restore),
    .go_save   (go_save)
  );

  nvsram_xfer #(
    .T_STORE (T_STORE),
    .T_RECALL(T_RECALL)
  ) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_restore(go_restore),
    .go_save   (go_save),
    .busy      (busy),
    .mode      (mode),
    .clr_all   (clr_all),
    .ld_from_nv(ld_from_nv),
    .sv_to_nv  (sv_to_nv)
  );

  nvsram_store #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_active(busy),
    .wr_en      (wr_en),
    .rd_en      (rd_acc),
    .idx        (addr[IDX_W-1:0]),
    .wdata      (wdata),
    .clr_all    (clr_all),
    .ld_from_nv (ld_from_nv),
    .sv_to_nv   (sv_to_nv),
    .rdata      (rd_word)
  );

  assign rdata = oe_n ? '0 : rd_word;

  AST_ONE_ACCESS_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !acc); // R11
  AST_SAVE_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && mode == XF_SAVE) |-> $past(pwr_good)); // R10

endmodule

// File: tb/nvsram_seq_tb_top.sv
module nvsram_seq_tb_top;

  localparam int unsigned TS = 20;
  localparam int unsigned TR = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, we_n, oe_n, pwr_good;
  logic [12:0] addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        busy;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  nvsram_seq #(.T_STORE(TS), .T_RECALL(TR)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwr_good(pwr_good),
    .busy(busy)
  );

  typedef struct packed {
    logic        wr;
    logic [12:0] a;
    logic [7:0]  d;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 13'h0003, 8'hA5, 8'h00},
    '{1'b1, 13'h0007, 8'h3C, 8'h00},
    '{1'b1, 13'h000F, 8'hFF, 8'h00},
    '{1'b0, 13'h0003, 8'h00, 8'hA5},
    '{1'b0, 13'h0007, 8'h00, 8'h3C},
    '{1'b0, 13'h000F, 8'h00, 8'hFF},
    '{1'b1, 13'h0013, 8'h5A, 8'h00},
    '{1'b0, 13'h0003, 8'h00, 8'h5A},
    '{1'b1, 13'h0003, 8'hA5, 8'h00},
    '{1'b0, 13'h0013, 8'h00, 8'hA5}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [12:0] a,
                        input logic [7:0] d, input int hold);
    @(negedge clk);
    ce_n = 1'b0; we_n = ~wr; addr = a; wdata = d;
    repeat (hold) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic key(input logic [12:0] last);
    access(1'b0, 13'h0000, 8'h0, 1);
    access(1'b0, 13'h1555, 8'h0, 1);
    access(1'b0, 13'h0AAA, 8'h0, 1);
    access(1'b0, 13'h1FFF, 8'h0, 1);
    access(1'b0, 13'h10F0, 8'h0, 1);
    access(1'b0, last,     8'h0, 1);
  endtask

  task automatic wait_idle(input string req, input int exp_n);
    int n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(req, n, exp_n);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; pwr_good = 1'b1;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 rdata", rdata, 0);
    access(1'b0, 13'h0005, 8'h0, 1);
    check("R1 array zero", rdata, 0);

    // R2 table walk of plain writes and reads
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].a, VECS[i].d, 1);
      if (!VECS[i].wr) check("R2 read", rdata, VECS[i].exp);
    end
    oe_n = 1'b1;
    @(negedge clk);
    check("R2 oe gate", rdata, 0);
    oe_n = 1'b0;

    // R4 save key
    key(13'h0FF0);
    check("R4 busy rise", busy, 1);
    wait_idle("R4 busy length", TS);

    // R3 restore with an ignored write during the transfer (R8)
    access(1'b1, 13'h0003, 8'h00, 1);
    access(1'b0, 13'h0003, 8'h00, 1);
    check("R2 overwrite", rdata, 8'h00);
    key(13'h0F0E);
    check("R3 busy rise", busy, 1);
    access(1'b1, 13'h0007, 8'h11, 1);
    wait_idle("R3 busy length", TR - 2);
    access(1'b0, 13'h0003, 8'h00, 1);
    check("R9 restored", rdata, 8'hA5);
    access(1'b0, 13'h0007, 8'h00, 1);
    check("R8 write ignored", rdata, 8'h3C);
    access(1'b0, 13'h0009, 8'h00, 1);
    check("R9 cleared word", rdata, 8'h00);

    // R9 repeatable restore
    access(1'b1, 13'h0003, 8'h77, 1);
    key(13'h0F0E);
    wait_idle("R9 second restore", TR);
    access(1'b0, 13'h0003, 8'h00, 1);
    check("R9 repeat", rdata, 8'hA5);

    // R5 write inside key breaks it
    access(1'b0, 13'h0000, 8'h0, 1);
    access(1'b0, 13'h1555, 8'h0, 1);
    access(1'b1, 13'h0AAA, 8'h0, 1);
    access(1'b0, 13'h0AAA, 8'h0, 1);
    access(1'b0, 13'h1FFF, 8'h0, 1);
    access(1'b0, 13'h10F0, 8'h0, 1);
    access(1'b0, 13'h0F0E, 8'h0, 1);
    check("R5 no start", busy, 0);

    // R6 mismatch at first key address restarts as step one
    access(1'b0, 13'h0000, 8'h0, 1);
    access(1'b0, 13'h1555, 8'h0, 1);
    key(13'h0F0E);
    check("R6 restart", busy, 1);
    wait_idle("R6 length", TR);
    access(1'b0, 13'h0000, 8'h0, 1);
    access(1'b0, 13'h0123, 8'h0, 1);
    access(1'b0, 13'h0AAA, 8'h0, 1);
    access(1'b0, 13'h1FFF, 8'h0, 1);
    access(1'b0, 13'h10F0, 8'h0, 1);
    access(1'b0, 13'h0F0E, 8'h0, 1);
    check("R6 mismatch resets", busy, 0);

    // R7 output enable high during key
    oe_n = 1'b1;
    key(13'h0F0E);
    check("R7 oe ignored", busy, 1);
    wait_idle("R7 length", TR);
    oe_n = 1'b0;

    // R11 held chip enable counts once
    access(1'b0, 13'h0000, 8'h0, 1);
    access(1'b0, 13'h1555, 8'h0, 1);
    access(1'b0, 13'h0AAA, 8'h0, 1);
    access(1'b0, 13'h1FFF, 8'h0, 1);
    access(1'b0, 13'h10F0, 8'h0, 3);
    access(1'b0, 13'h0F0E, 8'h0, 1);
    check("R11 single count", busy, 1);
    wait_idle("R11 length", TR);

    // R10 low power: write dropped, save refused
    pwr_good = 1'b0;
    access(1'b1, 13'h0009, 8'h55, 1);
    access(1'b0, 13'h0009, 8'h00, 1);
    check("R10 write blocked", rdata, 8'h00);
    key(13'h0FF0);
    check("R10 save refused", busy, 0);
    pwr_good = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule